// File: doc/BRIEF.md
# Pixel Hit Readout Serializer

This block turns the triggered hits of one pixel readout chip into a stream of digital symbols for a serial link. A readout begins when a start request arrives while the block is idle. The block first sends a two-symbol chip header. It then takes hits one at a time from a valid/ready stream. Each hit carries a column number, a pixel number and an amplitude sample.

Each hit occupies a fixed six-clock slot. The column and pixel numbers are packed most significant first into a 13-bit address and padded with leading zeros to 15 bits. That address goes out as five 3-bit symbols, each zero-extended onto the 8-bit symbol bus. The sixth clock carries the full 8-bit amplitude.

The two header values both exceed 7, so no address symbol can imitate them. A readout ends at the first slot boundary where no hit is offered. A readout that finds no hit therefore consists of the header alone.

Top module: `pix_readout_ser`

## Requirements
- R1: When `start_i` is high in a cycle where the block is idle, the next cycle shows symbol 0xA5 with `sym_valid_o` high, and the cycle after that shows 0x5A with `sym_valid_o` high.
- R2: The address is A = {2'b00, col[5:0], pix[6:0]} (15 bits). Address symbol k (k = 0..4) equals A[14-3k -: 3], zero-extended to 8 bits, so every address symbol is at most 7.
- R3: A hit accepted in cycle t puts its five address symbols on the bus in cycles t+1 to t+5, with no gap between them.
- R4: The accepted hit's 8-bit amplitude is on the bus in cycle t+6.
- R5: `hit_ready_o` is high exactly in the cycles where the bus shows the second header symbol or an amplitude symbol. It is low while idle and while address symbols are shown. A hit is taken only when `hit_valid_i` and `hit_ready_o` are both high.
- R6: If no hit is offered in a cycle where `hit_ready_o` is high, the next cycle shows `sym_valid_o` low and `sym_o` = 0, and the block is idle. A readout with no hits is the two header symbols only.
- R7: `start_i` is ignored while a readout is in progress, including the final cycle of a readout. Only a start seen while idle opens a new header.
- R8: During and after reset, with no start request, `sym_valid_o`, `sym_o` and `hit_ready_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a readout |
| hit_valid_i | input | 1 | A hit is offered |
| hit_ready_o | output | 1 | Slot boundary: an offered hit is taken this cycle |
| hit_col_i | input | 6 | Column number of the offered hit |
| hit_pix_i | input | 7 | Pixel number of the offered hit |
| hit_amp_i | input | 8 | Amplitude sample of the offered hit |
| sym_o | output | 8 | Current output symbol |
| sym_valid_o | output | 1 | `sym_o` carries a symbol |

## Verification
Three events can coincide in one cycle: the end of a slot, the decision to close the readout, and a new start request. The bench holds `start_i` high throughout a readout and drops the hit offer partway through. This makes a start request land on the closing boundary. It also offers hits while the block is idle. A behavioural model built from a queue of expected symbols judges every cycle. Per the model, a start request on the closing boundary is ignored and a new header opens only one idle cycle later.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HDR0 = 3'd1,
        ST_HDR1 = 3'd2,
        ST_ADDR = 3'd3,
        ST_AMP  = 3'd4
    } ser_state_e;
endpackage

// File: rtl/pix_ser_hit_pack.sv
module pix_ser_hit_pack #(
    parameter int COL_W  = 6,
    parameter int PIX_W  = 7,
    parameter int ADDR_W = 15
) (
    input  logic [COL_W-1:0]  col_i,
    input  logic [PIX_W-1:0]  pix_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAD_W = ADDR_W - COL_W - PIX_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign addr_o = {{PAD_W{1'b0}}, col_i, pix_i};
        end else begin : g_nopad
            assign addr_o = {col_i, pix_i};
        end
    endgenerate
endmodule

// File: rtl/pix_ser_addr_slice.sv
module pix_ser_addr_slice #(
    parameter int SYM_W = 3,
    parameter int NSYM  = 5,
    parameter int IDX_W = 3,
    parameter int OUT_W = 8
) (
    input  logic [NSYM*SYM_W-1:0] addr_i,
    input  logic [IDX_W-1:0]      idx_i,
    output logic [OUT_W-1:0]      sym_o
);
    logic [SYM_W-1:0] part [NSYM];

    // symbol 0 is the most significant slice
    for (genvar g = 0; g < NSYM; g++) begin : g_part
        assign part[g] = addr_i[(NSYM-1-g)*SYM_W +: SYM_W];
    end

    always_comb begin
        sym_o = '0;
        for (int k = 0; k < NSYM; k++) begin
            if (idx_i == IDX_W'(k)) begin
                sym_o = OUT_W'(part[k]);
            end
        end
    end
endmodule

// File: rtl/pix_readout_ser.sv
module pix_readout_ser #(
    parameter int          COL_W = 6,
    parameter int          PIX_W = 7,
    parameter int          AMP_W = 8,
    parameter int          SYM_W = 3,
    parameter logic [7:0]  HDR_A = 8'hA5,
    parameter logic [7:0]  HDR_B = 8'h5A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hit_valid_i,
    output logic             hit_ready_o,
    input  logic [COL_W-1:0] hit_col_i,
    input  logic [PIX_W-1:0] hit_pix_i,
    input  logic [AMP_W-1:0] hit_amp_i,
    output logic [7:0]       sym_o,
    output logic             sym_valid_o
);
    import pix_ser_pkg::*;

    localparam int RAW_W  = COL_W + PIX_W;
    localparam int NSYM   = (RAW_W + SYM_W - 1) / SYM_W;
    localparam int ADDR_W = NSYM * SYM_W;
    localparam int IDX_W  = (NSYM > 1) ? $clog2(NSYM) : 1;
    localparam int OUT_W  = 8;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSYM - 1);

    typedef struct packed {
        ser_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [AMP_W-1:0]  amp;
        logic [OUT_W-1:0]  sym;
        logic              vld;
    } ser_regs_t;

    ser_regs_t r_q, r_d;

    logic              boundary;
    logic              take;
    logic [ADDR_W-1:0] new_addr;
    logic [ADDR_W-1:0] sel_addr;
    logic [IDX_W-1:0]  sel_idx;
    logic [OUT_W-1:0]  slice_sym;

    pix_ser_hit_pack #(
        .COL_W (COL_W),
        .PIX_W (PIX_W),
        .ADDR_W(ADDR_W)
    ) u_pack (
        .col_i (hit_col_i),
        .pix_i (hit_pix_i),
        .addr_o(new_addr)
    );

    // a slot boundary is the last cycle of the header or of a hit
    assign boundary = (r_q.st == ST_HDR1) || (r_q.st == ST_AMP);
    assign take     = boundary && hit_valid_i;

    always_comb begin
        sel_addr = take ? new_addr : r_q.addr;
        sel_idx  = take ? '0 : IDX_W'(r_q.idx + 1'b1);
    end

    pix_ser_addr_slice #(
        .SYM_W(SYM_W),
        .NSYM (NSYM),
        .IDX_W(IDX_W),
        .OUT_W(OUT_W)
    ) u_slice (
        .addr_i(sel_addr),
        .idx_i (sel_idx),
        .sym_o (slice_sym)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_HDR0;
                    r_d.sym = HDR_A;
                    r_d.vld = 1'b1;
                end
            end
            ST_HDR0: begin
                r_d.st  = ST_HDR1;
                r_d.sym = HDR_B;
            end
            ST_HDR1, ST_AMP: begin
                if (take) begin
                    r_d.st   = ST_ADDR;
                    r_d.idx  = '0;
                    r_d.addr = new_addr;
                    r_d.amp  = hit_amp_i;
                    r_d.sym  = slice_sym;
                end else begin
                    r_d.st  = ST_IDLE;
                    r_d.sym = '0;
                    r_d.vld = 1'b0;
                end
            end
            ST_ADDR: begin
                if (r_q.idx == LAST_IDX) begin
                    r_d.st  = ST_AMP;
                    r_d.sym = OUT_W'(r_q.amp);
                end else begin
                    r_d.idx = sel_idx;
                    r_d.sym = slice_sym;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.sym = '0;
                r_d.vld = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hit_ready_o = boundary;
    assign sym_o       = r_q.sym;
    assign sym_valid_o = r_q.vld;
endmodule

// File: rtl/pix_ser_chk.sv
module pix_ser_chk #(
    parameter int         SYM_W = 3,
    parameter logic [7:0] HDR_A = 8'hA5,
    parameter logic [7:0] HDR_B = 8'h5A
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hit_valid_i,
    input logic       hit_ready_o,
    input logic [7:0] sym_o,
    input logic       sym_valid_o
);
    // R1
    hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_valid_o) |-> sym_o == HDR_A);

    // R1
    hdr_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_valid_o) |=> (sym_valid_o && sym_o == HDR_B));

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid_i && hit_ready_o) |=> (sym_valid_o && sym_o < 8'(1 << SYM_W)));

    // R5
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid_i && hit_ready_o) |=> !hit_ready_o);

    // R6
    end_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sym_valid_o) |-> $past(hit_ready_o));

    // R6
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_valid_o |-> (sym_o == 8'd0 && !hit_ready_o));
endmodule

bind pix_readout_ser pix_ser_chk #(
    .SYM_W(SYM_W),
    .HDR_A(HDR_A),
    .HDR_B(HDR_B)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_valid_i(hit_valid_i),
    .hit_ready_o(hit_ready_o),
    .sym_o      (sym_o),
    .sym_valid_o(sym_valid_o)
);

// File: tb/pix_readout_ser_tb.sv
module pix_readout_ser_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       offer = 1'b0;
    logic       hit_valid;
    logic       hit_ready;
    logic [5:0] hit_col;
    logic [6:0] hit_pix;
    logic [7:0] hit_amp;
    logic [7:0] sym;
    logic       sym_valid;

    logic [5:0] hcol [32];
    logic [6:0] hpix [32];
    logic [7:0] hamp [32];
    int         hn = 0;
    int         hidx = 0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // expected symbols still to be shown, with their kind: 1 header, 2 address, 3 amplitude
    logic [7:0] eq [$];
    int         ek [$];
    bit         busy = 1'b0;

    always #4 clk = ~clk;

    assign hit_valid = offer && (hidx < hn);
    assign hit_col   = hcol[hidx[4:0]];
    assign hit_pix   = hpix[hidx[4:0]];
    assign hit_amp   = hamp[hidx[4:0]];

    pix_readout_ser u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .hit_valid_i(hit_valid),
        .hit_ready_o(hit_ready),
        .hit_col_i  (hit_col),
        .hit_pix_i  (hit_pix),
        .hit_amp_i  (hit_amp),
        .sym_o      (sym),
        .sym_valid_o(sym_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq.delete();
            ek.delete();
            busy = 1'b0;
        end else if (busy) begin
            void'(eq.pop_front());
            void'(ek.pop_front());
            if (eq.size() == 0) begin
                if (hit_valid) begin
                    logic [14:0] a;
                    a = {2'b00, hit_col, hit_pix};
                    for (int k = 0; k < 5; k++) begin
                        eq.push_back(8'((a >> (12 - 3 * k)) & 15'd7));
                        ek.push_back(2);
                    end
                    eq.push_back(hit_amp);
                    ek.push_back(3);
                    hidx <= hidx + 1;
                end else begin
                    busy = 1'b0;
                end
            end
        end else if (start) begin
            eq.push_back(8'hA5);
            ek.push_back(1);
            eq.push_back(8'h5A);
            ek.push_back(1);
            busy = 1'b1;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (busy) begin
                string tg;
                tg = (ek[0] == 1) ? "R1" : (ek[0] == 2) ? "R2/R3" : "R4";
                chk(sym_valid && sym == eq[0], tg, {sym_valid, sym}, {1'b1, eq[0]});
                chk(hit_ready == (eq.size() == 1), "R5", hit_ready, (eq.size() == 1));
            end else begin
                chk(!sym_valid && sym == 8'd0, "R6/R7", {sym_valid, sym}, 0);
                chk(!hit_ready, "R5", hit_ready, 0);
            end
        end
    end

    task automatic add_hit(input logic [5:0] c, input logic [6:0] p, input logic [7:0] a);
        hcol[hn] = c;
        hpix[hn] = p;
        hamp[hn] = a;
        hn++;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            hcol[i] = '0;
            hpix[i] = '0;
            hamp[i] = '0;
        end
        idle(3);
        // R8: outputs quiet while in reset
        chk(!sym_valid && sym == 8'd0 && !hit_ready, "R8", {hit_ready, sym_valid, sym}, 0);
        rst_n = 1'b1;
        idle(3);
        // R8: still quiet after reset with no request
        chk(!sym_valid && sym == 8'd0 && !hit_ready, "R8", {hit_ready, sym_valid, sym}, 0);

        // R6: empty readout, header only
        pulse_start();
        idle(6);

        // R5: hit offered while idle is not taken; R2 extreme address values
        add_hit(6'd63, 7'd127, 8'hFF);
        offer = 1'b1;
        idle(5);
        chk(hidx == 0, "R5", hidx, 0);
        pulse_start();
        idle(12);

        // R3/R4: back-to-back hits, amplitudes that look like header values
        add_hit(6'd0, 7'd0, 8'h00);
        add_hit(6'd21, 7'd42, 8'hA5);
        add_hit(6'd5, 7'd100, 8'h5A);
        pulse_start();
        idle(25);

        // R6: offer withdrawn partway, readout closes early, rest in a second readout
        add_hit(6'd33, 7'd1, 8'h11);
        add_hit(6'd12, 7'd64, 8'h22);
        add_hit(6'd40, 7'd77, 8'h33);
        add_hit(6'd7, 7'd9, 8'h44);
        pulse_start();
        idle(9);
        offer = 1'b0;
        idle(15);
        offer = 1'b1;
        pulse_start();
        idle(30);

        // R7: start held high through a readout and its closing boundary
        add_hit(6'd50, 7'd3, 8'h7E);
        add_hit(6'd2, 7'd120, 8'h81);
        @(negedge clk);
        start = 1'b1;
        idle(24);
        start = 1'b0;
        idle(12);
        chk(hidx == hn, "R7", hidx, hn);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule